// File: doc/BRIEF.md
# External Sync Slave Lock

This block ties an internal raster time base to an external active-low sync input. Two enables select what is tracked. With the vertical enable set, a low level on the input at the start of a line's active area causes the time base to restart its line count. With the horizontal enable set, the block looks for the external falling edge in a two-pixel window around the rising edge of the internal horizontal pulse. When the edge is missing from that window, it asks the time base to stretch the current line by one pixel. When both enables are clear, the block is silent and the time base runs free.

The external input is brought into the pixel clock domain by a chain of reset-to-high flops before anything samples it. The vertical path only looks at the level at the active-start strobe. It therefore works both with a vertical-only sync and with a composite sync whose short line pulses fall outside the active area. When the external line rate is locked to the pixel clock, each stretch moves the internal line by one pixel against the external one, so the phase is caught within one line period's worth of lines. A status flag reports when the edge has been found on several lines in a row.

Top module: `sync_slave_lock`

## Requirements
- R1: After a synchronous reset, `vreset`, `extend_req` and `locked` are 0. With `vert_en` and `horz_en` both 0, neither `vreset` nor `extend_req` ever goes high.
- R2: When `vert_en` is 1, `act_start` is 1 and the synchronised input is 0 at a clock edge, `vreset` is 1 for the next cycle only.
- R3: A low synchronised input in a cycle where `act_start` is 0 does not raise `vreset`. A composite sync whose line pulses avoid the active start therefore yields `vreset` only on lines held low at the active start.
- R4: When `vert_en` is 0, `vreset` stays 0 whatever `sync_in_n` and `act_start` do.
- R5: The edge window takes the synchronised input in the cycle before the cycle in which `hpulse` rises (0 to 1), and again in the cycle after it. The edge counts as found only when the first sample is 1 and the second is 0.
- R6: When `horz_en` is 1 and the edge is not found, `extend_req` is 1 for exactly one cycle. That cycle is the one after the second window sample, which is two cycles after the cycle in which `hpulse` rose.
- R7: When `horz_en` is 0, `extend_req` stays 0. At most one `extend_req` pulse is produced per `hpulse` rise.
- R8: `locked` goes to 1 once the edge has been found on `LOCK_LINES` (default 4) consecutive windows with `horz_en` at 1. It returns to 0 on the first window that misses or whenever `horz_en` is 0.
- R9: `sync_in_n` passes through `SYNC_STAGES` (default 2) flops that reset to 1 before either path samples it. A change at the pin therefore reaches the sampling logic two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in_n | input | 1 | External active-low sync, asynchronous |
| vert_en | input | 1 | Enable for vertical line-counter restart |
| horz_en | input | 1 | Enable for horizontal phase tracking |
| hpulse | input | 1 | Internal horizontal pulse; its rising edge is the reference |
| act_start | input | 1 | One-cycle strobe on the first pixel of each line's active area |
| vreset | output | 1 | One-cycle request to clear the vertical line counter |
| extend_req | output | 1 | One-cycle request to lengthen the current line by one pixel |
| locked | output | 1 | Horizontal phase has been caught on consecutive lines |

## Verification
The bench runs a closed loop in which its own time base stretches a line whenever `extend_req` appears. It checks that the phase walks into the window and that `locked` rises and stays high. A window misplaced by one cycle would never lock, or would lock at the wrong phase and keep stretching. Composite-sync lines check that short line pulses landing on non-active pixels cause no vertical restart; a design that sampled on every low cycle would reset the line count every line. Random input in master mode, and dropping `horz_en` while locked, catch requests that leak through a disabled path or a status flag that is not cleared.

// File: rtl/sls_pkg.sv
package sls_pkg;

    localparam int unsigned SLS_SYNC_STAGES = 2;
    localparam int unsigned SLS_LOCK_LINES  = 4;

    // snapshot of the horizontal edge window
    typedef struct packed {
        logic armed;     // second sample is due this cycle
        logic early;     // synchronised level one cycle before the pulse rise
    } sls_window_t;

    typedef enum logic [1:0] {
        SLS_IDLE  = 2'd0,
        SLS_HIT   = 2'd1,
        SLS_MISS  = 2'd2
    } sls_verdict_t;

    function automatic sls_verdict_t sls_judge(input sls_window_t w, input logic late);
        if (!w.armed)
            return SLS_IDLE;
        else if (w.early && !late)
            return SLS_HIT;
        else
            return SLS_MISS;
    endfunction

endpackage

// File: rtl/sls_sync.sv
module sls_sync #(
    parameter int unsigned STAGES = sls_pkg::SLS_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[LAST];

endmodule

// File: rtl/sls_vlock.sv
module sls_vlock (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic act_start,
    input  logic sync_s,
    output logic vreset
);
    always_ff @(posedge clk) begin
        if (rst) vreset <= 1'b0;
        else     vreset <= en && act_start && !sync_s;
    end

    // R4: a restart request needs the enable and the strobe one cycle earlier
    a_r4_vreset_needs_enable: assert property (@(posedge clk) disable iff (rst)
        vreset |-> $past(en && act_start));

    // R2: a restart request follows a low synchronised sample
    a_r2_vreset_low_sample: assert property (@(posedge clk) disable iff (rst)
        vreset |-> $past(!sync_s));

endmodule

// File: rtl/sls_hlock.sv
module sls_hlock #(
    parameter int unsigned LOCK_LINES = sls_pkg::SLS_LOCK_LINES
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic hpulse,
    input  logic sync_s,
    output logic extend_req,
    output logic locked
);
    import sls_pkg::*;

    localparam int unsigned CW = $clog2(LOCK_LINES + 1);
    localparam logic [CW-1:0] CMAX = CW'(LOCK_LINES);

    logic          hp_q;
    logic          sync_q;
    sls_window_t   win;
    sls_verdict_t  verdict;
    logic [CW-1:0] run_cnt;
    logic          rise;

    assign rise    = hpulse && !hp_q;
    assign verdict = sls_judge(win, sync_s);
    assign locked  = (run_cnt == CMAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            hp_q       <= 1'b0;
            sync_q     <= 1'b1;
            win        <= '0;
            extend_req <= 1'b0;
            run_cnt    <= '0;
        end else begin
            hp_q      <= hpulse;
            sync_q    <= sync_s;
            win.armed <= rise;
            if (rise)
                win.early <= sync_q;
            extend_req <= en && (verdict == SLS_MISS);
            if (!en)
                run_cnt <= '0;
            else if (verdict == SLS_MISS)
                run_cnt <= '0;
            else if (verdict == SLS_HIT && run_cnt != CMAX)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    // R7: no stretch request unless the enable was high
    a_r7_no_extend_when_off: assert property (@(posedge clk) disable iff (rst)
        extend_req |-> $past(en));

    // R6: a stretch request lasts one cycle
    a_r6_extend_single: assert property (@(posedge clk) disable iff (rst)
        extend_req |=> !extend_req);

    // R8: a miss and the lock flag never coexist
    a_r8_miss_clears_lock: assert property (@(posedge clk) disable iff (rst)
        extend_req |-> !locked);

    // R8: dropping the enable clears the lock flag
    a_r8_lock_drops_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !locked);

endmodule

// File: rtl/sync_slave_lock.sv
module sync_slave_lock #(
    parameter int unsigned SYNC_STAGES = sls_pkg::SLS_SYNC_STAGES,
    parameter int unsigned LOCK_LINES  = sls_pkg::SLS_LOCK_LINES
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in_n,
    input  logic vert_en,
    input  logic horz_en,
    input  logic hpulse,
    input  logic act_start,
    output logic vreset,
    output logic extend_req,
    output logic locked
);
    logic sync_s;

    sls_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sync_in_n),
        .dout (sync_s)
    );

    sls_vlock u_vlock (
        .clk       (clk),
        .rst       (rst),
        .en        (vert_en),
        .act_start (act_start),
        .sync_s    (sync_s),
        .vreset    (vreset)
    );

    sls_hlock #(.LOCK_LINES(LOCK_LINES)) u_hlock (
        .clk        (clk),
        .rst        (rst),
        .en         (horz_en),
        .hpulse     (hpulse),
        .sync_s     (sync_s),
        .extend_req (extend_req),
        .locked     (locked)
    );

    // R1: in master mode no request leaves the block
    a_r1_master_silent: assert property (@(posedge clk) disable iff (rst)
        (!$past(vert_en) && !$past(horz_en)) |-> (!vreset && !extend_req));

endmodule

// File: tb/sync_slave_lock_bench.sv
module sync_slave_lock_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_in_n = 1'b1;
    logic vert_en = 1'b0;
    logic horz_en = 1'b0;
    logic hpulse = 1'b0;
    logic act_start = 1'b0;
    logic vreset, extend_req, locked;

    always #2.5 clk = ~clk;   // 200 MHz

    sync_slave_lock u_sync_slave_lock (
        .clk        (clk),
        .rst        (rst),
        .sync_in_n  (sync_in_n),
        .vert_en    (vert_en),
        .horz_en    (horz_en),
        .hpulse     (hpulse),
        .act_start  (act_start),
        .vreset     (vreset),
        .extend_req (extend_req),
        .locked     (locked)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // ---------------- reference model ----------------
    bit s_hist[$] = '{1, 1, 1, 1, 1, 1};  // index 0 = level taken at latest edge
    bit hp_prev = 0;
    bit armed_m = 0;
    int run_m = 0;
    bit e_vr = 0, e_ext = 0, e_lock = 0;

    always @(posedge clk) begin
        bit found;
        s_hist.push_front(rst ? 1'b1 : sync_in_n);
        if (s_hist.size() > 6) void'(s_hist.pop_back());
        // synchronised level seen before this edge is s_hist[2] (R9)
        e_vr  = !rst && vert_en && act_start && !s_hist[2];
        found = s_hist[4] && !s_hist[2];
        e_ext = !rst && horz_en && armed_m && !found;
        if (rst || !horz_en) run_m = 0;
        else if (armed_m) run_m = found ? ((run_m < 4) ? run_m + 1 : 4) : 0;
        e_lock = (run_m >= 4);
        armed_m = !rst && hpulse && !hp_prev;
        hp_prev = rst ? 1'b0 : hpulse;
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    int vr_seen = 0, ext_seen = 0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2", "vreset", vreset, e_vr);
            check("R6", "extend_req", extend_req, e_ext);
            check("R8", "locked", locked, e_lock);
            if (vreset) vr_seen++;
            if (extend_req) ext_seen++;
        end
    end

    // ---------------- stimulus ----------------
    int ipos = 0, ilen = 20, epos = 0, line_idx = 0, mode = 0;

    task automatic step();
        @(negedge clk);
        if (extend_req) ilen = ilen + 1;
        hpulse    = (ipos >= 10 && ipos < 13);
        act_start = (ipos == 14);
        case (mode)
            0: sync_in_n = 1'($urandom_range(0, 1));
            1: sync_in_n = !((line_idx % 8) inside {2, 3});
            2: sync_in_n = !((ipos >= 9 && ipos < 12) || (line_idx % 8) == 2);
            default: sync_in_n = !(epos < 4);
        endcase
        ipos++;
        if (ipos >= ilen) begin
            ipos = 0;
            ilen = 20;
            line_idx++;
        end
        epos = (epos + 1) % 20;
    endtask

    task automatic run_lines(input int n);
        int target;
        target = line_idx + n;
        while (line_idx < target) step();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1", "vreset after reset", vreset, 1'b0);
        check("R1", "extend_req after reset", extend_req, 1'b0);
        check("R1", "locked after reset", locked, 1'b0);
        rst = 1'b0;

        // R1: master mode with random input
        mode = 0; vert_en = 0; horz_en = 0;
        vr_seen = 0; ext_seen = 0;
        run_lines(10);
        check("R1", "no vreset in master mode", vr_seen != 0, 1'b0);
        check("R1", "no extend in master mode", ext_seen != 0, 1'b0);

        // R4: vertical disabled, line held low
        mode = 1; vert_en = 0;
        vr_seen = 0;
        run_lines(8);
        check("R4", "no vreset when vertical disabled", vr_seen != 0, 1'b0);

        // R2 / R9: vertical-only sync
        vert_en = 1;
        vr_seen = 0;
        run_lines(16);
        check("R2", "four restarts over two frames", vr_seen == 4, 1'b1);

        // R3: composite sync, one low line per frame
        mode = 2;
        vr_seen = 0;
        run_lines(16);
        check("R3", "restarts only on low lines", vr_seen == 2, 1'b1);

        // R5 / R6 / R8: horizontal tracking closes the loop
        mode = 3; vert_en = 0; horz_en = 1;
        run_lines(40);
        check("R8", "locked after capture", locked, 1'b1);
        ext_seen = 0;
        run_lines(10);
        check("R6", "no stretch once phase is held", ext_seen != 0, 1'b0);
        check("R8", "lock held", locked, 1'b1);

        // R7 / R8: drop horizontal enable
        horz_en = 0;
        ext_seen = 0;
        epos = (epos + 7) % 20;   // disturb the phase
        run_lines(6);
        check("R7", "no stretch when horizontal disabled", ext_seen != 0, 1'b0);
        check("R8", "lock cleared when disabled", locked, 1'b0);

        // R5 / R6: re-enable from a wrong phase, misses must produce stretches
        horz_en = 1;
        ext_seen = 0;
        run_lines(3);
        check("R6", "stretch requested on miss", ext_seen > 0, 1'b1);
        check("R7", "at most one stretch per line", ext_seen <= 3, 1'b1);
        run_lines(30);
        check("R5", "window recaptures edge", locked, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule